// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks reservations for load-linked and store-conditional pairs on cache lines. It is given one completion event per cycle. Each event carries a line address, a 3-bit request kind, the requester's ID, and a flag that says whether the line is resident in the cache. A load-linked completion records a reservation for its line, owned by the requester that issued it. A store-conditional completion tests that reservation, reports the outcome, and then removes the reservation for the line. Any other write-class completion from the owning requester to a resident line also removes the reservation.

The block holds a small parameterised table of reservation entries. When a load-linked finds no free entry, it evicts the entry that was allocated earliest. The block also tracks one locked read-modify-write line. A locked read completion marks the line blocked, and the matching locked write completion releases it.

Each completion produces a registered response bit one cycle later. The response bit is 1 for success and 0 for failure, and is returned with the response as its extra-data value. Table updates are written at the clock edge that consumes the completion, so a completion in the very next cycle already sees them.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked completion (kind 2) always reports 1. It leaves a reservation on its line owned by its requester ID. If the line is already reserved, the owner becomes the new requester.
- R2: A store-conditional completion (kind 3) reports 1 only when its line holds a reservation owned by the same requester ID. In every other case it reports 0.
- R3: `rsp_valid` is high in the cycle after each completion and low otherwise. `rsp_success` carries 1 for success and 0 for failure, and is 0 whenever `rsp_valid` is 0.
- R4: Every store-conditional removes the reservation on its line, whoever owns it and whatever the outcome. A second store-conditional to that line therefore reports 0.
- R5: A completion of kind 1 (store), 4 (locked read), 5 (locked write) or 6 (atomic) is a write-class completion and reports 1. It removes the reservation on its line only when `line_present` is 1 and the reservation is owned by the same requester ID. A write-class completion from another ID, or one with `line_present` at 0, leaves the reservation in place.
- R6: A kind-4 completion makes `lock_active` 1 and `lock_line` its address from the next cycle onward. A kind-5 completion whose address equals `lock_line` makes `lock_active` 0 from the next cycle onward. A kind-5 completion to any other address leaves the lock unchanged.
- R7: At most ENTRIES lines are reserved at once. A load-linked to an unreserved line, when no entry is free, evicts the reservation allocated earliest. A reservation removed by R4 or R5 frees its entry for reuse.
- R8: Kinds 0 (load) and 7 (spare) report 1 and change neither the reservations nor the lock. Cycles with `cpl_valid` at 0 change nothing.
- R9: After reset no line is reserved, `rsp_valid` and `rsp_success` are 0, and `lock_active` is 0.
- R10: A completion in the cycle right after another completion observes the reservation changes made by the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpl_valid | input | 1 | A completion is presented this cycle |
| cpl_kind | input | 3 | Completion kind code (see R1, R2, R5, R6, R8) |
| cpl_line | input | ADDR_W | Line address of the completion |
| cpl_id | input | ID_W | Requester ID of the completion |
| line_present | input | 1 | The line is resident in the cache |
| rsp_valid | output | 1 | Response for last cycle's completion |
| rsp_success | output | 1 | Result value: 1 success, 0 failure |
| lock_active | output | 1 | A locked read-modify-write line is blocked |
| lock_line | output | ADDR_W | Address of the blocked line |

## Verification
The lock assertions assume at most one locked line at a time. They also assume that every locked write names the line that is currently blocked, or names no blocked line at all. The random stimulus therefore issues a locked read only while no line is blocked. It issues a locked write only while a line is blocked, aiming it at that line or at a deliberately different one. The reservation assertions assume nothing about ordering: any mix of kinds, IDs and residency flags is legal. The stimulus draws from six line addresses, which is more than the table holds, and from three requester IDs, so that eviction, cross-requester store-conditionals and owner transfer all occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        CK_LOAD    = 3'd0,
        CK_STORE   = 3'd1,
        CK_LINK    = 3'd2,
        CK_COND    = 3'd3,
        CK_LOCK_RD = 3'd4,
        CK_LOCK_WR = 3'd5,
        CK_ATOMIC  = 3'd6,
        CK_SPARE   = 3'd7
    } cpl_kind_e;

    localparam logic RESULT_PASS = 1'b1;
    localparam logic RESULT_FAIL = 1'b0;

    function automatic logic is_write_class(cpl_kind_e k);
        return (k == CK_STORE) || (k == CK_LOCK_RD) ||
               (k == CK_LOCK_WR) || (k == CK_ATOMIC);
    endfunction

endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ID_W    = 6,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  cpl_kind_e         ev_kind,
    input  logic [ADDR_W-1:0] ev_line,
    input  logic [ID_W-1:0]   ev_id,
    input  logic              line_present,
    output logic              own_hit
);
    localparam int RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES - 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] line;
        logic [ID_W-1:0]   owner;
        logic [RANK_W-1:0] rank;
    } resv_t;

    resv_t tab_q [ENTRIES];
    resv_t tab_d [ENTRIES];

    logic [ENTRIES-1:0] addr_hit, owner_hit, clr_vec;
    logic [RANK_W-1:0]  free_idx, victim_idx, alloc_idx, clr_rank;
    logic               free_found;
    logic               is_link, is_cond, is_wr, do_alloc;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign addr_hit[g]  = tab_q[g].vld && (tab_q[g].line == ev_line);
        assign owner_hit[g] = addr_hit[g] && (tab_q[g].owner == ev_id);
    end

    assign own_hit  = |owner_hit;
    assign is_link  = ev_valid && (ev_kind == CK_LINK);
    assign is_cond  = ev_valid && (ev_kind == CK_COND);
    assign is_wr    = ev_valid && is_write_class(ev_kind) && line_present;
    assign do_alloc = is_link && !(|addr_hit);
    assign clr_vec  = is_cond ? addr_hit : (is_wr ? owner_hit : '0);

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        victim_idx = '0;
        clr_rank   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!tab_q[i].vld && !free_found) begin
                free_found = 1'b1;
                free_idx   = RANK_W'(i);
            end
            if (tab_q[i].vld && tab_q[i].rank == OLDEST) victim_idx = RANK_W'(i);
            if (clr_vec[i]) clr_rank = tab_q[i].rank;
        end
        alloc_idx = free_found ? free_idx : victim_idx;
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tab_d[i] = tab_q[i];
            if (is_link && addr_hit[i]) tab_d[i].owner = ev_id;
            if (do_alloc) begin
                if (RANK_W'(i) == alloc_idx) begin
                    tab_d[i].vld   = 1'b1;
                    tab_d[i].line  = ev_line;
                    tab_d[i].owner = ev_id;
                    tab_d[i].rank  = '0;
                end else if (tab_q[i].vld) begin
                    tab_d[i].rank = tab_q[i].rank + 1'b1;
                end
            end
            if (|clr_vec) begin
                if (clr_vec[i]) begin
                    tab_d[i].vld  = 1'b0;
                    tab_d[i].rank = '0;
                end else if (tab_q[i].vld && tab_q[i].rank > clr_rank) begin
                    tab_d[i].rank = tab_q[i].rank - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) tab_q[i] <= '0;
            else     tab_q[i] <= tab_d[i];
        end
    end

    // Checking support: remember the last event and search the table for it.
    logic              chk_v;
    cpl_kind_e         chk_kind;
    logic [ADDR_W-1:0] chk_line;
    logic [ID_W-1:0]   chk_id;
    logic              chk_line_held, chk_own_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v    <= 1'b0;
            chk_kind <= CK_LOAD;
            chk_line <= '0;
            chk_id   <= '0;
        end else begin
            chk_v    <= ev_valid;
            chk_kind <= ev_kind;
            chk_line <= ev_line;
            chk_id   <= ev_id;
        end
    end

    always_comb begin
        chk_line_held = 1'b0;
        chk_own_held  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tab_q[i].vld && tab_q[i].line == chk_line) begin
                chk_line_held = 1'b1;
                if (tab_q[i].owner == chk_id) chk_own_held = 1'b1;
            end
        end
    end

    p_link_reserves_r1: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_kind == CK_LINK) |-> chk_own_held);

    p_cond_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_kind == CK_COND) |-> !chk_line_held);

    // R7: valid entries hold distinct lines and distinct age ranks.
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = i + 1; j < ENTRIES; j++) begin
                    p_unique_entries_r7: assert (!(tab_q[i].vld && tab_q[j].vld) ||
                        (tab_q[i].rank != tab_q[j].rank && tab_q[i].line != tab_q[j].line));
                end
            end
        end
    end

endmodule

// File: rtl/llsc_lock_track.sv
module llsc_lock_track
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  cpl_kind_e         ev_kind,
    input  logic [ADDR_W-1:0] ev_line,
    output logic              lock_active,
    output logic [ADDR_W-1:0] lock_line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_active <= 1'b0;
            lock_line   <= '0;
        end else if (ev_valid && ev_kind == CK_LOCK_RD) begin
            lock_active <= 1'b1;
            lock_line   <= ev_line;
        end else if (ev_valid && ev_kind == CK_LOCK_WR && ev_line == lock_line) begin
            lock_active <= 1'b0;
        end
    end

    p_lock_set_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == CK_LOCK_RD) |=> (lock_active && lock_line == $past(ev_line)));

    p_lock_release_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == CK_LOCK_WR && lock_active && ev_line == lock_line)
        |=> !lock_active);

    p_lock_ignores_load_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == CK_LOAD || ev_kind == CK_SPARE)) |=> $stable(lock_active));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ID_W    = 6,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_kind,
    input  logic [ADDR_W-1:0] cpl_line,
    input  logic [ID_W-1:0]   cpl_id,
    input  logic              line_present,
    output logic              rsp_valid,
    output logic              rsp_success,
    output logic              lock_active,
    output logic [ADDR_W-1:0] lock_line
);
    cpl_kind_e kind;
    logic      own_hit;
    logic      result;

    assign kind   = cpl_kind_e'(cpl_kind);
    assign result = (kind == CK_COND) ? (own_hit ? RESULT_PASS : RESULT_FAIL) : RESULT_PASS;

    llsc_resv_table #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .ENTRIES(ENTRIES)
    ) resv_i (
        .clk         (clk),
        .rst         (rst),
        .ev_valid    (cpl_valid),
        .ev_kind     (kind),
        .ev_line     (cpl_line),
        .ev_id       (cpl_id),
        .line_present(line_present),
        .own_hit     (own_hit)
    );

    llsc_lock_track #(
        .ADDR_W(ADDR_W)
    ) lock_i (
        .clk        (clk),
        .rst        (rst),
        .ev_valid   (cpl_valid),
        .ev_kind    (kind),
        .ev_line    (cpl_line),
        .lock_active(lock_active),
        .lock_line  (lock_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_success <= 1'b0;
        end else begin
            rsp_valid   <= cpl_valid;
            rsp_success <= cpl_valid && result;
        end
    end

    p_non_cond_passes_r8: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && kind != CK_COND) |=> (rsp_valid && rsp_success));

    p_foreign_cond_fails_r2: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && kind == CK_COND && !own_hit) |=> (rsp_valid && !rsp_success));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !cpl_valid |=> (!rsp_valid && !rsp_success));

endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
    localparam int ADDR_W  = 32;
    localparam int ID_W    = 6;
    localparam int ENTRIES = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpl_valid = 1'b0;
    logic [2:0]        cpl_kind = 3'd0;
    logic [ADDR_W-1:0] cpl_line = '0;
    logic [ID_W-1:0]   cpl_id = '0;
    logic              line_present = 1'b0;
    logic              rsp_valid, rsp_success, lock_active;
    logic [ADDR_W-1:0] lock_line;

    always #2 clk = ~clk;

    llsc_monitor #(.ADDR_W(ADDR_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) dut_i (
        .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
        .cpl_line(cpl_line), .cpl_id(cpl_id), .line_present(line_present),
        .rsp_valid(rsp_valid), .rsp_success(rsp_success),
        .lock_active(lock_active), .lock_line(lock_line)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: reservations in allocation order, oldest at the front.
    logic [ADDR_W-1:0] m_line [$];
    logic [ID_W-1:0]   m_own  [$];
    logic              m_lk_v = 1'b0;
    logic [ADDR_W-1:0] m_lk_a = '0;
    logic              e_valid = 1'b0, e_succ = 1'b0;
    string             e_tag = "R9";

    function automatic int find_line(logic [ADDR_W-1:0] a);
        for (int i = 0; i < m_line.size(); i++) if (m_line[i] == a) return i;
        return -1;
    endfunction

    task automatic model(bit v, logic [2:0] k, logic [ADDR_W-1:0] a,
                         logic [ID_W-1:0] id, bit pres);
        int idx;
        e_valid = v;
        e_succ  = 1'b0;
        e_tag   = "R8";
        if (!v) begin
            e_tag = "R3";
            return;
        end
        idx    = find_line(a);
        e_succ = 1'b1;
        case (k)
            3'd2: begin
                e_tag = "R1";
                if (idx >= 0) m_own[idx] = id;
                else begin
                    if (m_line.size() == ENTRIES) begin
                        e_tag = "R7";
                        void'(m_line.pop_front());
                        void'(m_own.pop_front());
                    end
                    m_line.push_back(a);
                    m_own.push_back(id);
                end
            end
            3'd3: begin
                e_tag  = "R2/R4";
                e_succ = (idx >= 0) && (m_own[idx] == id);
                if (idx >= 0) begin
                    m_line.delete(idx);
                    m_own.delete(idx);
                end
            end
            3'd1, 3'd4, 3'd5, 3'd6: begin
                e_tag = "R5";
                if (pres && idx >= 0 && m_own[idx] == id) begin
                    m_line.delete(idx);
                    m_own.delete(idx);
                end
                if (k == 3'd4) begin
                    e_tag  = "R6";
                    m_lk_v = 1'b1;
                    m_lk_a = a;
                end else if (k == 3'd5 && a == m_lk_a) begin
                    e_tag  = "R6";
                    m_lk_v = 1'b0;
                end
            end
            default: e_tag = "R8";
        endcase
    endtask

    task automatic compare();
        bit bad;
        checks++;
        bad = (rsp_valid !== e_valid) || (rsp_success !== e_succ) ||
              (lock_active !== m_lk_v) || (m_lk_v && lock_line !== m_lk_a);
        if (bad) begin
            fails++;
            $display("FAIL %s: valid/success/lock/line = %b/%b/%b/%h expected %b/%b/%b/%h",
                     e_tag, rsp_valid, rsp_success, lock_active, lock_line,
                     e_valid, e_succ, m_lk_v, m_lk_a);
        end
    endtask

    // Drive one completion at a falling edge, then check after the next rising edge.
    task automatic step(bit v, logic [2:0] k, logic [ADDR_W-1:0] a,
                        logic [ID_W-1:0] id, bit pres);
        cpl_valid    = v;
        cpl_kind     = k;
        cpl_line     = a;
        cpl_id       = id;
        line_present = pres;
        model(v, k, a, id, pres);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    localparam logic [ADDR_W-1:0] LA = 32'h100, LB = 32'h140, LC = 32'h180,
                                  LD = 32'h1C0, LE = 32'h200, LF = 32'h240;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        e_valid = 1'b0; e_succ = 1'b0; e_tag = "R9";
        compare();
        rst = 1'b0;

        // R1, R2, R3, R4, R10: pair succeeds, repeat fails back-to-back
        step(1, 3'd2, LA, 1, 1);
        step(1, 3'd3, LA, 1, 1);
        step(1, 3'd3, LA, 1, 1);
        // R4: a foreign store-conditional fails yet clears the owner's reservation
        step(1, 3'd2, LA, 1, 1);
        step(1, 3'd3, LA, 2, 1);
        step(1, 3'd3, LA, 1, 1);
        // R5: a foreign store keeps the reservation; an absent line keeps it; own atomic clears
        step(1, 3'd2, LB, 0, 1);
        step(1, 3'd1, LB, 1, 1);
        step(1, 3'd3, LB, 0, 1);
        step(1, 3'd2, LC, 2, 1);
        step(1, 3'd6, LC, 2, 0);
        step(1, 3'd6, LC, 2, 1);
        step(1, 3'd3, LC, 2, 1);
        // R7: the fifth line evicts the oldest; R8: loads and idles change nothing
        step(1, 3'd2, LA, 0, 1);
        step(1, 3'd2, LB, 0, 1);
        step(1, 3'd2, LC, 0, 1);
        step(1, 3'd2, LD, 0, 1);
        step(1, 3'd0, LB, 0, 1);
        step(0, 3'd0, LB, 0, 1);
        step(1, 3'd7, LB, 0, 1);
        step(1, 3'd2, LE, 0, 1);
        step(1, 3'd3, LA, 0, 1);
        step(1, 3'd3, LB, 0, 1);
        // R1: owner transfer
        step(1, 3'd2, LF, 1, 1);
        step(1, 3'd2, LF, 2, 1);
        step(1, 3'd3, LF, 1, 1);
        // R6: lock set, unrelated release ignored, matching release clears
        step(1, 3'd4, LF, 3, 1);
        step(1, 3'd5, LA, 3, 1);
        step(1, 3'd5, LF, 3, 1);

        // Random traffic across all kinds
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [ADDR_W-1:0] a;
            logic [2:0] k;
            r = $urandom_range(0, 9);
            a = LA + ADDR_W'(($urandom_range(0, 5)) * 32'h40);
            case (r)
                0, 1, 2: k = 3'd2;
                3, 4:    k = 3'd3;
                5:       k = 3'd1;
                6:       k = 3'd6;
                7:       k = ($urandom_range(0, 1) != 0) ? 3'd0 : 3'd7;
                9: begin
                    if (!m_lk_v) k = 3'd4;
                    else begin
                        k = 3'd5;
                        if ($urandom_range(0, 2) != 0) a = m_lk_a;
                        else if (a == m_lk_a) a = a + 32'h1000;
                    end
                end
                default: k = 3'd0;
            endcase
            step(r != 8, k, a, ID_W'($urandom_range(0, 2)), $urandom_range(0, 3) != 0);
        end
        step(0, 3'd0, '0, '0, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule